// File: doc/BRIEF.md
# Banked Scratchpad Conflict Arbiter

This block sits in front of a banked on-chip scratchpad. One request carries one access for each of 32 lanes. Each access has a byte address, a size code, a write enable and up to 128 bits of write data. The storage is split into 32 banks, each one 32 bits wide. Consecutive 32-bit words go to consecutive banks. In each cycle the arbiter serves every pending lane whose bank words do not collide with a lower-numbered pending lane. It holds the rest for later cycles. It also keeps a running count of the extra cycles that bank collisions cost.

Lanes that touch the same word are merged into one bank access. Readers of that word all receive the same data. Halfword writers each land in their own half of the word. Full-word writers resolve to the highest-numbered lane. When any lane in a request asks for 16 bytes, the request runs in phases of eight lanes. Eight such accesses cover all 32 banks, so a well-formed wide request finishes one phase per cycle and costs no counted conflict. A phase change is never counted as a conflict.

The request side uses a valid/ready handshake. Ready is low while a request is being worked off. A one-cycle done pulse marks the cycle in which the per-lane read data is complete.

Top module: `scratch_bank_arb`

## Requirements
- R1: A byte address selects bank (address / 4) mod 32 and row address / 128. Size code 2'b00 is 2 bytes (address bit 0 ignored), 2'b01 or 2'b11 is 4 bytes (bits 1:0 ignored), and 2'b10 is 16 bytes (bits 3:0 ignored).
- R2: If every lane of a request touches a different bank, the request finishes in one cycle and the conflict count does not change.
- R3: Lanes that touch the same bank at different rows are served one row per cycle. A request with N service cycles in a single phase adds N-1 to the count, so a 32-lane request with a 128-byte stride takes 32 cycles and adds 31.
- R4: Any number of lanes reading the same word take one cycle together, and each of them returns that word.
- R5: Two-byte lanes sharing a word are served in one cycle. A write stores each lane's bits 15:0 into the half chosen by address bit 1. A read returns that half in bits 15:0 with zeros above it.
- R6: Lanes 0-7, 8-15, 16-23 and 24-31 of a request that contains a 16-byte access form four phases, served in that order. Sixteen-byte lanes at consecutive 16-byte addresses take 4 cycles and add nothing to the count. Word k of a 16-byte access sits in data bits 32k+31:32k.
- R7: In phased mode, only the extra cycles inside a phase are counted. Lanes in different phases never conflict with each other.
- R8: When several lanes write the same word in the same cycle, each byte takes the value of the highest-numbered lane that writes it.
- R9: req_ready is high when idle and low from the accept edge until the done pulse. rsp_done is high for exactly one cycle, and a 4-byte read returns its word in bits 31:0 with zeros above it.
- R10: The 32-bit conflict count saturates at all ones. A high cnt_clr clears it at the next edge, and the clear takes priority over an increment in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Arbiter idle and able to accept |
| req_addr | input | 32*12 | Per-lane byte address, lane l at bits 12l+11:12l |
| req_size | input | 32*2 | Per-lane size code |
| req_we | input | 32 | Per-lane write enable |
| req_wdata | input | 32*128 | Per-lane write data |
| rsp_done | output | 1 | One-cycle pulse: request complete |
| rsp_rdata | output | 32*128 | Per-lane read data, valid from the done pulse |
| cnt_clr | input | 1 | Synchronous clear of the conflict count |
| conflict_cnt | output | 32 | Saturating count of conflict cycles |

## Verification
The conflict count can receive an increment from a serialized request and a clear from cnt_clr on the same clock edge. The bench provokes this by raising cnt_clr for a single cycle partway through a 32-cycle same-bank request. The clear must win: the final count must equal exactly the number of service cycles that follow the clear edge, and one more or one fewer shows the wrong priority. The done pulse and the re-raising of ready also fall in the same cycle, and each run checks that they agree.

// File: rtl/scratch_bank_arb.sv
module scratch_bank_arb #(
  parameter int LANES = 32,
  parameter int BANKS = 32,
  parameter int ROWS  = 32,
  parameter int CNT_W = 32
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            req_valid,
  output logic                            req_ready,
  input  logic [LANES*(2+$clog2(BANKS)+$clog2(ROWS))-1:0] req_addr,
  input  logic [LANES*2-1:0]              req_size,
  input  logic [LANES-1:0]                req_we,
  input  logic [LANES*128-1:0]            req_wdata,
  output logic                            rsp_done,
  output logic [LANES*128-1:0]            rsp_rdata,
  input  logic                            cnt_clr,
  output logic [CNT_W-1:0]                conflict_cnt
);
  localparam int BSEL = $clog2(BANKS);
  localparam int RSEL = $clog2(ROWS);
  localparam int AW   = 2 + BSEL + RSEL;
  localparam int DW   = 128;
  localparam int GRP  = BANKS / 4;
  localparam int NPH  = LANES / GRP;
  localparam int PW   = (NPH > 1) ? $clog2(NPH) : 1;
  localparam logic [1:0] SZ_HALF = 2'b00;
  localparam logic [1:0] SZ_WIDE = 2'b10;

  logic             busy, wide, first, done_q;
  logic [PW-1:0]    phase;
  logic [LANES-1:0] pend, act, srv, we_q;
  logic [AW-1:0]    a_q  [LANES];
  logic [1:0]       sz_q [LANES];
  logic [DW-1:0]    wd_q [LANES];
  logic [DW-1:0]    rd_q [LANES];
  logic [DW-1:0]    rd_v [LANES];
  logic [31:0]      mem  [BANKS][ROWS];
  logic [RSEL-1:0]  win_row [BANKS];
  logic [3:0]       wbe  [BANKS];
  logic [31:0]      wdat [BANKS];
  logic [3:0]       lane_be;
  logic [31:0]      lane_d;
  logic [CNT_W-1:0] cnt;
  logic             unused_lsb;

  function automatic logic [BSEL-1:0] bank_of(logic [AW-1:0] a);
    return a[BSEL+1:2];
  endfunction

  function automatic logic [RSEL-1:0] row_of(logic [AW-1:0] a);
    return a[AW-1:BSEL+2];
  endfunction

  function automatic logic hits(logic [AW-1:0] a, logic [1:0] sz, logic [BSEL-1:0] b);
    if (sz == SZ_WIDE) return b[BSEL-1:2] == a[BSEL+1:4];
    return b == a[BSEL+1:2];
  endfunction

  wire all_done = ((pend & ~srv) == '0);
  wire ph_done  = ((act & ~srv) == '0);

  assign req_ready    = !busy;
  assign rsp_done     = done_q;
  assign conflict_cnt = cnt;

  always_comb begin
    for (int l = 0; l < LANES; l++)
      act[l] = pend[l] && (!wide || (l / GRP) == int'(phase));
    for (int b = 0; b < BANKS; b++) begin
      win_row[b] = '0;
      for (int l = LANES - 1; l >= 0; l--)
        if (act[l] && hits(a_q[l], sz_q[l], BSEL'(b))) win_row[b] = row_of(a_q[l]);
    end
    for (int l = 0; l < LANES; l++) begin
      srv[l] = act[l];
      for (int b = 0; b < BANKS; b++)
        if (hits(a_q[l], sz_q[l], BSEL'(b)) && win_row[b] != row_of(a_q[l])) srv[l] = 1'b0;
    end
  end

  always_comb begin
    lane_be = '0;
    lane_d  = '0;
    for (int b = 0; b < BANKS; b++) begin
      wbe[b]  = '0;
      wdat[b] = '0;
      for (int l = 0; l < LANES; l++) begin
        if (srv[l] && we_q[l] && hits(a_q[l], sz_q[l], BSEL'(b))) begin
          case (sz_q[l])
            SZ_HALF: begin
              lane_d  = {2{wd_q[l][15:0]}};
              lane_be = a_q[l][1] ? 4'b1100 : 4'b0011;
            end
            SZ_WIDE: begin
              lane_d  = wd_q[l][32*(b%4)+:32];
              lane_be = 4'hf;
            end
            default: begin
              lane_d  = wd_q[l][31:0];
              lane_be = 4'hf;
            end
          endcase
          for (int k = 0; k < 4; k++)
            if (lane_be[k]) wdat[b][8*k+:8] = lane_d[8*k+:8];
          wbe[b] = wbe[b] | lane_be;
        end
      end
    end
  end

  always_comb begin
    unused_lsb = 1'b0;
    for (int l = 0; l < LANES; l++) begin
      unused_lsb = unused_lsb ^ a_q[l][0];
      case (sz_q[l])
        SZ_HALF:
          rd_v[l] = DW'(a_q[l][1] ? mem[bank_of(a_q[l])][row_of(a_q[l])][31:16]
                                  : mem[bank_of(a_q[l])][row_of(a_q[l])][15:0]);
        SZ_WIDE:
          for (int k = 0; k < 4; k++)
            rd_v[l][32*k+:32] = mem[{a_q[l][BSEL+1:4], 2'(k)}][row_of(a_q[l])];
        default:
          rd_v[l] = DW'(mem[bank_of(a_q[l])][row_of(a_q[l])]);
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      wide   <= 1'b0;
      first  <= 1'b0;
      done_q <= 1'b0;
      phase  <= '0;
      pend   <= '0;
      cnt    <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy && req_valid) begin
        busy  <= 1'b1;
        pend  <= '1;
        phase <= '0;
        first <= 1'b1;
        wide  <= 1'b0;
        for (int l = 0; l < LANES; l++)
          if (req_size[2*l+:2] == SZ_WIDE) wide <= 1'b1;
      end else if (busy) begin
        pend <= pend & ~srv;
        if (all_done) begin
          busy   <= 1'b0;
          done_q <= 1'b1;
        end else if (ph_done) begin
          phase <= phase + 1'b1;
          first <= 1'b1;
        end else begin
          first <= 1'b0;
        end
      end
      if (cnt_clr) cnt <= '0;
      else if (busy && !first && cnt != '1) cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!busy && req_valid)
      for (int l = 0; l < LANES; l++) begin
        a_q[l]  <= req_addr[AW*l+:AW];
        sz_q[l] <= req_size[2*l+:2];
        we_q[l] <= req_we[l];
        wd_q[l] <= req_wdata[DW*l+:DW];
      end
    if (busy) begin
      for (int l = 0; l < LANES; l++)
        if (srv[l]) rd_q[l] <= rd_v[l];
      for (int b = 0; b < BANKS; b++)
        for (int k = 0; k < 4; k++)
          if (wbe[b][k]) mem[b][win_row[b]][8*k+:8] <= wdat[b][8*k+:8];
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_out
    assign rsp_rdata[DW*l+:DW] = rd_q[l];
  end
endmodule

// File: rtl/scratch_bank_arb_chk.sv
module scratch_bank_arb_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             rsp_done,
  input logic             cnt_clr,
  input logic [CNT_W-1:0] conflict_cnt
);
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);

  p_ready_with_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> req_ready);

  p_accept_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  p_clear_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clr |=> conflict_cnt == '0);

  p_saturate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (conflict_cnt == '1 && !cnt_clr) |=> conflict_cnt == '1);

  p_step_by_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_clr |=> (conflict_cnt == $past(conflict_cnt)) ||
                 (conflict_cnt == $past(conflict_cnt) + 1'b1));

  p_idle_no_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && !cnt_clr) |=> $stable(conflict_cnt));
endmodule

bind scratch_bank_arb scratch_bank_arb_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_done(rsp_done), .cnt_clr(cnt_clr), .conflict_cnt(conflict_cnt)
);

// File: tb/scratch_bank_arb_tb.sv
module scratch_bank_arb_tb_top;
  localparam int L  = 32;
  localparam int AW = 12;
  localparam int DW = 128;

  logic            clk = 1'b0, rst_n = 1'b0;
  logic            req_valid = 1'b0, cnt_clr = 1'b0;
  logic            req_ready, rsp_done;
  logic [L*AW-1:0] req_addr  = '0;
  logic [L*2-1:0]  req_size  = '0;
  logic [L-1:0]    req_we    = '0;
  logic [L*DW-1:0] req_wdata = '0;
  logic [L*DW-1:0] rsp_rdata;
  logic [31:0]     conflict_cnt;

  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  scratch_bank_arb dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_size(req_size), .req_we(req_we), .req_wdata(req_wdata),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .cnt_clr(cnt_clr),
    .conflict_cnt(conflict_cnt)
  );

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic set_lane(input int l, input int addr, input logic [1:0] sz,
                          input logic we, input logic [127:0] d);
    req_addr[AW*l+:AW] = AW'(addr);
    req_size[2*l+:2]   = sz;
    req_we[l]          = we;
    req_wdata[DW*l+:DW] = d;
  endtask

  function automatic logic [127:0] lane_rd(input int l);
    return rsp_rdata[DW*l+:DW];
  endfunction

  task automatic run(input int clr_at, output int cyc);
    bit ready_bad = 0;
    @(negedge clk);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    cyc = 0;
    while (!rsp_done && cyc < 2000) begin
      if (req_ready) ready_bad = 1;
      cnt_clr = (clr_at > 0 && cyc == clr_at);
      @(negedge clk);
      cyc++;
    end
    cnt_clr = 1'b0;
    chk(!ready_bad && req_ready, "R9 ready low while busy, high at done", 128'(req_ready), 128'(1));
    @(negedge clk);
    chk(!rsp_done, "R9 done lasts one cycle", 128'(rsp_done), 128'(0));
  endtask

  task automatic t_reset;
    chk(req_ready == 1'b1, "R9 ready after reset", 128'(req_ready), 128'(1));
    chk(rsp_done == 1'b0, "R9 no done after reset", 128'(rsp_done), 128'(0));
    chk(conflict_cnt == 0, "R10 count after reset", 128'(conflict_cnt), 128'(0));
  endtask

  task automatic t_distinct_banks;
    int cyc; logic [31:0] c0;
    for (int l = 0; l < L; l++) set_lane(l, 4*l, 2'b01, 1'b1, 128'(32'hA000 + l));
    c0 = conflict_cnt;
    run(0, cyc);
    chk(cyc == 1, "R2 distinct-bank write cycles", 128'(cyc), 128'(1));
    chk(conflict_cnt == c0, "R2 distinct-bank write count", 128'(conflict_cnt), 128'(c0));
    for (int l = 0; l < L; l++) set_lane(l, 4*((l+5)%32), 2'b11, 1'b0, '0);
    run(0, cyc);
    chk(cyc == 1, "R2 permuted read cycles", 128'(cyc), 128'(1));
    for (int l = 0; l < L; l++)
      chk(lane_rd(l) == 128'(32'hA000 + (l+5)%32), "R1 R9 bank map readback",
          lane_rd(l), 128'(32'hA000 + (l+5)%32));
  endtask

  task automatic t_stride;
    int cyc; logic [31:0] c0;
    for (int l = 0; l < L; l++) set_lane(l, 128*l, 2'b01, 1'b1, 128'(32'h5000 + l));
    c0 = conflict_cnt;
    run(0, cyc);
    chk(cyc == 32, "R3 same-bank write cycles", 128'(cyc), 128'(32));
    chk(conflict_cnt == c0 + 31, "R3 same-bank write count", 128'(conflict_cnt), 128'(c0 + 31));
    for (int l = 0; l < L; l++) set_lane(l, 128*l, 2'b01, 1'b0, '0);
    c0 = conflict_cnt;
    run(0, cyc);
    chk(cyc == 32 && conflict_cnt == c0 + 31, "R3 same-bank read cycles/count",
        128'(conflict_cnt - c0), 128'(31));
    for (int l = 0; l < L; l++)
      chk(lane_rd(l) == 128'(32'h5000 + l), "R3 same-bank readback", lane_rd(l), 128'(32'h5000 + l));
  endtask

  task automatic t_broadcast;
    int cyc; logic [31:0] c0;
    for (int l = 0; l < L; l++) set_lane(l, 640, 2'b01, 1'b0, '0);
    c0 = conflict_cnt;
    run(0, cyc);
    chk(cyc == 1 && conflict_cnt == c0, "R4 broadcast single cycle", 128'(cyc), 128'(1));
    for (int l = 0; l < L; l++)
      chk(lane_rd(l) == 128'(32'h5005), "R4 broadcast data", lane_rd(l), 128'(32'h5005));
  endtask

  task automatic t_halfword;
    int cyc; logic [31:0] c0; logic [127:0] e;
    for (int l = 0; l < L; l++) set_lane(l, 256 + 2*l, 2'b00, 1'b1, {112'h1234, 16'hB000 + 16'(l)});
    c0 = conflict_cnt;
    run(0, cyc);
    chk(cyc == 1 && conflict_cnt == c0, "R5 halfword write merged", 128'(cyc), 128'(1));
    for (int l = 0; l < L; l++) set_lane(l, 256 + 4*(l%16), 2'b01, 1'b0, '0);
    run(0, cyc);
    chk(cyc == 1, "R5 word read of halves cycles", 128'(cyc), 128'(1));
    for (int l = 0; l < L; l++) begin
      e = 128'({16'hB000 + 16'(2*(l%16)+1), 16'hB000 + 16'(2*(l%16))});
      chk(lane_rd(l) == e, "R5 halves placed by address bit 1", lane_rd(l), e);
    end
    for (int l = 0; l < L; l++) set_lane(l, 256 + 2*l, 2'b00, 1'b0, '0);
    run(0, cyc);
    for (int l = 0; l < L; l++)
      chk(lane_rd(l) == 128'(16'hB000 + 16'(l)), "R5 halfword read zero-extended",
          lane_rd(l), 128'(16'hB000 + 16'(l)));
  endtask

  task automatic t_same_word_write;
    int cyc;
    for (int l = 0; l < L; l++) set_lane(l, 1032, 2'b01, 1'b1, 128'(32'hC000 + l));
    run(0, cyc);
    chk(cyc == 1, "R8 same-word write cycles", 128'(cyc), 128'(1));
    for (int l = 0; l < L; l++) set_lane(l, 1032, 2'b01, 1'b0, '0);
    run(0, cyc);
    chk(lane_rd(7) == 128'(32'hC01F), "R8 highest lane wins", lane_rd(7), 128'(32'hC01F));
  endtask

  function automatic logic [127:0] wide_val(input int l);
    logic [127:0] v;
    for (int k = 0; k < 4; k++) v[32*k+:32] = 32'hD000_0000 + 32'(l*16 + k);
    return v;
  endfunction

  task automatic t_wide;
    int cyc; logic [31:0] c0;
    for (int l = 0; l < L; l++) set_lane(l, 1536 + 16*l, 2'b10, 1'b1, wide_val(l));
    c0 = conflict_cnt;
    run(0, cyc);
    chk(cyc == 4, "R6 wide write phases", 128'(cyc), 128'(4));
    chk(conflict_cnt == c0, "R6 wide write no conflict", 128'(conflict_cnt), 128'(c0));
    for (int l = 0; l < L; l++) set_lane(l, 1536 + 16*l, 2'b10, 1'b0, '0);
    run(0, cyc);
    chk(cyc == 4, "R6 wide read phases", 128'(cyc), 128'(4));
    for (int l = 0; l < L; l++)
      chk(lane_rd(l) == wide_val(l), "R6 wide readback", lane_rd(l), wide_val(l));
    for (int l = 0; l < L; l++) set_lane(l, 1536 + 4*l, 2'b01, 1'b0, '0);
    run(0, cyc);
    for (int l = 0; l < L; l++)
      chk(lane_rd(l) == 128'(32'hD000_0000 + 32'((l/4)*16 + l%4)), "R6 word order in wide access",
          lane_rd(l), 128'(32'hD000_0000 + 32'((l/4)*16 + l%4)));
  endtask

  task automatic t_phases;
    int cyc; logic [31:0] c0;
    for (int l = 0; l < L; l++) set_lane(l, 1536 + 128*(l/8) + 16*(l%8), 2'b10, 1'b0, '0);
    c0 = conflict_cnt;
    run(0, cyc);
    chk(cyc == 4 && conflict_cnt == c0, "R7 cross-phase bank reuse not counted",
        128'(conflict_cnt - c0), 128'(0));
    set_lane(1, 1536 + 128, 2'b10, 1'b0, '0);
    c0 = conflict_cnt;
    run(0, cyc);
    chk(cyc == 5, "R7 in-phase conflict cycles", 128'(cyc), 128'(5));
    chk(conflict_cnt == c0 + 1, "R7 in-phase conflict counted", 128'(conflict_cnt), 128'(c0 + 1));
    chk(lane_rd(1) == wide_val(8), "R7 delayed lane data", lane_rd(1), wide_val(8));
  endtask

  task automatic t_clear;
    int cyc;
    for (int l = 0; l < L; l++) set_lane(l, 128*l, 2'b01, 1'b0, '0);
    run(10, cyc);
    chk(cyc == 32, "R10 run length under clear", 128'(cyc), 128'(32));
    chk(conflict_cnt == 21, "R10 clear beats increment", 128'(conflict_cnt), 128'(21));
    @(negedge clk); cnt_clr = 1'b1;
    @(negedge clk); cnt_clr = 1'b0;
    chk(conflict_cnt == 0, "R10 idle clear", 128'(conflict_cnt), 128'(0));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_distinct_banks();
    t_stride();
    t_broadcast();
    t_halfword();
    t_same_word_write();
    t_wide();
    t_phases();
    t_clear();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule